// File: doc/BRIEF.md
# DRAM Software Command Injector

This block sits on a Wishbone slave port and lets firmware drive a DRAM command interface directly while the memory is being brought up. Software sets the static pin levels (clock enable, reset, on-die termination) through a control register and loads a row/column address and a bank number into two holding registers. A write to the command register then produces a single-clock DRAM command, such as a mode-register set, with the chosen strobes and the stored address. Software is responsible for all spacing between commands.

One control bit hands the pins over to a hardware memory controller. While that bit is set, every DRAM-side output follows the controller's bypass inputs with no added latency. The bus side uses classic single-beat Wishbone: a request is accepted in the cycle where `wb_cyc_i` and `wb_stb_i` are high and no acknowledge is pending. `wb_ack_o` rises in the next cycle for exactly one clock. The master holds the request until it sees that acknowledge, and the block never stalls beyond it.

Top module: `dram_cmd_injector`

## Requirements
- R1: An accepted request is acknowledged in the following cycle with `wb_ack_o` high for exactly one clock. `wb_ack_o` never rises unless both `wb_cyc_i` and `wb_stb_i` were high in the previous cycle.
- R2: The control register sits at byte offset 0x00 and holds bit 0 (hand-over to hardware), bit 1 (CKE), bit 2 (RESET_N) and bit 3 (ODT). It reads back these four bits. When bit 0 is clear, `dram_cke`, `dram_reset_n` and `dram_odt` follow bits 1, 2 and 3, so 0x0C gives CKE low with ODT and RESET_N high, and 0x0E gives all three high.
- R3: The address register at offset 0x0C and the bank register at offset 0x10 read back what was written, truncated to the output widths. When control bit 0 is clear, they drive `dram_addr` and `dram_bank`, and those values are present in the same cycle as a command strobe.
- R4: A write to the command register at offset 0x04 uses bit 0 for CS, bit 1 for WE, bit 2 for CAS and bit 3 for RAS. Each set bit drives its active-low pin low for exactly the one cycle in which the write is acknowledged. The command register always reads 0.
- R5: In software mode, when no command is being issued, all four command pins are high (deselect).
- R6: When control bit 0 is set, every DRAM output equals the matching hardware input in the same cycle, and software command writes do not reach the pins.
- R7: Reset clears every register. During and after reset, all four command pins are high, CKE, RESET_N and ODT are low, and `wb_ack_o` is low.
- R8: Offsets 0x08, 0x14, 0x18 and 0x1C read as 0, and writes to them change no register and issue no command.
- R9: A read from any offset, including the command register, issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADR_W | Byte offset; bits [4:2] select the register |
| wb_dat_i | input | DW | Write data |
| wb_dat_o | output | DW | Read data, valid with ack |
| wb_ack_o | output | 1 | Acknowledge |
| hw_cs_n | input | 1 | Bypass chip select |
| hw_ras_n | input | 1 | Bypass RAS |
| hw_cas_n | input | 1 | Bypass CAS |
| hw_we_n | input | 1 | Bypass WE |
| hw_addr | input | AW | Bypass address |
| hw_bank | input | BW | Bypass bank |
| hw_cke | input | 1 | Bypass clock enable |
| hw_reset_n | input | 1 | Bypass DRAM reset |
| hw_odt | input | 1 | Bypass termination |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | RAS, active low |
| dram_cas_n | output | 1 | CAS, active low |
| dram_we_n | output | 1 | WE, active low |
| dram_addr | output | AW | Address |
| dram_bank | output | BW | Bank |
| dram_cke | output | 1 | Clock enable |
| dram_reset_n | output | 1 | DRAM reset, active low |
| dram_odt | output | 1 | On-die termination |

## Verification
On every cycle, the embedded assertions check the following: the acknowledge is one clock wide and is only raised after a real request; the control register changes only on its own write; a command strobe never lasts beyond one clock and never appears without a command-register write in the previous cycle. Only the bench's scenarios can show the rest. These are the mapping of each command bit to its pin, the address and bank appearing together with the strobe, the readback and zero reads, the harmlessness of unmapped writes and of reads, and the hand-over to the hardware inputs.

// File: rtl/dci_pkg.sv
package dci_pkg;
  localparam int IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_CTRL = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CMD  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_ADDR = 3'd3;
  localparam logic [IDX_W-1:0] IDX_BANK = 3'd4;

  localparam int CTL_HW   = 0;
  localparam int CTL_CKE  = 1;
  localparam int CTL_RSTN = 2;
  localparam int CTL_ODT  = 3;
  localparam int CTL_W    = 4;

  localparam int CMD_CS  = 0;
  localparam int CMD_WE  = 1;
  localparam int CMD_CAS = 2;
  localparam int CMD_RAS = 3;
  localparam int CMD_W   = 4;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic cs_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cs_n: 1'b1};
endpackage

// File: rtl/dci_regs.sv
module dci_regs
  import dci_pkg::*;
#(
  parameter int ADR_W = 5,
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int BW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADR_W-1:0]  wb_adr_i,
  input  logic [DW-1:0]     wb_dat_i,
  output logic [DW-1:0]     wb_dat_o,
  output logic              wb_ack_o,
  output logic [CTL_W-1:0]  ctrl_q,
  output logic [AW-1:0]     addr_q,
  output logic [BW-1:0]     bank_q,
  output logic              cmd_fire,
  output logic [CMD_W-1:0]  cmd_sel
);
  logic             ack_q;
  logic             accept;
  logic             wr;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    rd_mux;

  assign accept   = wb_cyc_i & wb_stb_i & ~ack_q;
  assign wr       = accept & wb_we_i;
  assign idx      = wb_adr_i[IDX_W+1:2];
  assign cmd_fire = wr && (idx == IDX_CMD);
  assign cmd_sel  = wb_dat_i[CMD_W-1:0];
  assign wb_ack_o = ack_q;

  always_comb begin
    unique case (idx)
      IDX_CTRL: rd_mux = DW'(ctrl_q);
      IDX_ADDR: rd_mux = DW'(addr_q);
      IDX_BANK: rd_mux = DW'(bank_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      ctrl_q   <= '0;
      addr_q   <= '0;
      bank_q   <= '0;
      wb_dat_o <= '0;
    end else begin
      ack_q <= accept;
      if (accept && !wb_we_i) wb_dat_o <= rd_mux;
      if (wr) begin
        case (idx)
          IDX_CTRL: ctrl_q <= wb_dat_i[CTL_W-1:0];
          IDX_ADDR: addr_q <= wb_dat_i[AW-1:0];
          IDX_BANK: bank_q <= wb_dat_i[BW-1:0];
          default:  ;
        endcase
      end
    end
  end

  assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  assert_ack_needs_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $past(wb_cyc_i && wb_stb_i));
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && idx == IDX_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/dci_cmd_pulse.sv
module dci_cmd_pulse
  import dci_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [CMD_W-1:0] sel,
  output cmd_pins_t        pins
);
  logic [CMD_W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= fire ? sel : '0;
  end

  always_comb begin
    pins.ras_n = ~act_q[CMD_RAS];
    pins.cas_n = ~act_q[CMD_CAS];
    pins.we_n  = ~act_q[CMD_WE];
    pins.cs_n  = ~act_q[CMD_CS];
  end

  assert_strobe_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|act_q) |=> (act_q == '0));
  assert_strobe_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|act_q) |-> $past(fire));
endmodule

// File: rtl/dci_out_mux.sv
module dci_out_mux
  import dci_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 3
) (
  input  logic             hw_mode,
  input  cmd_pins_t        sw_pins,
  input  logic [AW-1:0]    sw_addr,
  input  logic [BW-1:0]    sw_bank,
  input  logic [CTL_W-1:0] sw_ctrl,
  input  cmd_pins_t        hw_pins,
  input  logic [AW-1:0]    hw_addr,
  input  logic [BW-1:0]    hw_bank,
  input  logic             hw_cke,
  input  logic             hw_reset_n,
  input  logic             hw_odt,
  output cmd_pins_t        out_pins,
  output logic [AW-1:0]    out_addr,
  output logic [BW-1:0]    out_bank,
  output logic             out_cke,
  output logic             out_reset_n,
  output logic             out_odt
);
  always_comb begin
    if (hw_mode) begin
      out_pins    = hw_pins;
      out_addr    = hw_addr;
      out_bank    = hw_bank;
      out_cke     = hw_cke;
      out_reset_n = hw_reset_n;
      out_odt     = hw_odt;
    end else begin
      out_pins    = sw_pins;
      out_addr    = sw_addr;
      out_bank    = sw_bank;
      out_cke     = sw_ctrl[CTL_CKE];
      out_reset_n = sw_ctrl[CTL_RSTN];
      out_odt     = sw_ctrl[CTL_ODT];
    end
  end
endmodule

// File: rtl/dram_cmd_injector.sv
module dram_cmd_injector
  import dci_pkg::*;
#(
  parameter int ADR_W = 5,
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int BW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [ADR_W-1:0] wb_adr_i,
  input  logic [DW-1:0]    wb_dat_i,
  output logic [DW-1:0]    wb_dat_o,
  output logic             wb_ack_o,
  input  logic             hw_cs_n,
  input  logic             hw_ras_n,
  input  logic             hw_cas_n,
  input  logic             hw_we_n,
  input  logic [AW-1:0]    hw_addr,
  input  logic [BW-1:0]    hw_bank,
  input  logic             hw_cke,
  input  logic             hw_reset_n,
  input  logic             hw_odt,
  output logic             dram_cs_n,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic [AW-1:0]    dram_addr,
  output logic [BW-1:0]    dram_bank,
  output logic             dram_cke,
  output logic             dram_reset_n,
  output logic             dram_odt
);
  logic [CTL_W-1:0] ctrl_q;
  logic [AW-1:0]    addr_q;
  logic [BW-1:0]    bank_q;
  logic             cmd_fire;
  logic [CMD_W-1:0] cmd_sel;
  cmd_pins_t        sw_pins;
  cmd_pins_t        hw_pins;
  cmd_pins_t        out_pins;

  dci_regs #(.ADR_W(ADR_W), .DW(DW), .AW(AW), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
    .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
    .ctrl_q(ctrl_q), .addr_q(addr_q), .bank_q(bank_q),
    .cmd_fire(cmd_fire), .cmd_sel(cmd_sel)
  );

  dci_cmd_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(cmd_fire), .sel(cmd_sel), .pins(sw_pins)
  );

  assign hw_pins = '{ras_n: hw_ras_n, cas_n: hw_cas_n, we_n: hw_we_n, cs_n: hw_cs_n};

  dci_out_mux #(.AW(AW), .BW(BW)) u_mux (
    .hw_mode(ctrl_q[CTL_HW]),
    .sw_pins(sw_pins), .sw_addr(addr_q), .sw_bank(bank_q), .sw_ctrl(ctrl_q),
    .hw_pins(hw_pins), .hw_addr(hw_addr), .hw_bank(hw_bank),
    .hw_cke(hw_cke), .hw_reset_n(hw_reset_n), .hw_odt(hw_odt),
    .out_pins(out_pins), .out_addr(dram_addr), .out_bank(dram_bank),
    .out_cke(dram_cke), .out_reset_n(dram_reset_n), .out_odt(dram_odt)
  );

  assign dram_ras_n = out_pins.ras_n;
  assign dram_cas_n = out_pins.cas_n;
  assign dram_we_n  = out_pins.we_n;
  assign dram_cs_n  = out_pins.cs_n;
endmodule

// File: tb/dram_cmd_injector_test.sv
module dram_cmd_injector_test;
  localparam int AW = 16;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [4:0] wb_adr = '0;
  logic [31:0] wb_dat_i = '0;
  logic [31:0] wb_dat_o;
  logic wb_ack;
  logic hw_cs_n = 1, hw_ras_n = 1, hw_cas_n = 1, hw_we_n = 1;
  logic [AW-1:0] hw_addr = '0;
  logic [BW-1:0] hw_bank = '0;
  logic hw_cke = 0, hw_reset_n = 0, hw_odt = 0;
  logic dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n;
  logic [AW-1:0] dram_addr;
  logic [BW-1:0] dram_bank;
  logic dram_cke, dram_reset_n, dram_odt;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [3:0] cap_pins, post_pins;
  logic cap_ack, post_ack;
  logic [AW-1:0] cap_addr;
  logic [BW-1:0] cap_bank;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  dram_cmd_injector uut (
    .clk(clk), .rst_n(rst_n),
    .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_we_i(wb_we),
    .wb_adr_i(wb_adr), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack),
    .hw_cs_n(hw_cs_n), .hw_ras_n(hw_ras_n), .hw_cas_n(hw_cas_n), .hw_we_n(hw_we_n),
    .hw_addr(hw_addr), .hw_bank(hw_bank), .hw_cke(hw_cke), .hw_reset_n(hw_reset_n),
    .hw_odt(hw_odt),
    .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_bank(dram_bank),
    .dram_cke(dram_cke), .dram_reset_n(dram_reset_n), .dram_odt(dram_odt)
  );

  function automatic logic [3:0] pins();
    return {dram_ras_n, dram_cas_n, dram_we_n, dram_cs_n};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [4:0] adr, input logic [31:0] dat);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = adr; wb_dat_i = dat;
    @(negedge clk);
    cap_ack = wb_ack; cap_pins = pins(); cap_addr = dram_addr; cap_bank = dram_bank;
    rd = wb_dat_o;
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
    @(negedge clk);
    post_ack = wb_ack; post_pins = pins();
  endtask

  // {cmd[3:0], expected {ras_n,cas_n,we_n,cs_n}, addr[15:0], bank[7:0]}
  localparam logic [31:0] VEC [8] = '{
    32'hF0_0200_02, 32'h1E_0400_00, 32'h78_0000_05, 32'h96_1234_03,
    32'hD2_FFFF_07, 32'h0F_00AA_01, 32'hB4_5555_06, 32'h3C_8001_04
  };

  initial begin
    #(5ns * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7", "ack", wb_ack, 0);
    check("R7", "pins", pins(), 4'hF);
    check("R7", "cke/rst/odt", {dram_cke, dram_reset_n, dram_odt}, 0);
    rst_n = 1;
    bus(0, 5'h00, 0); check("R7", "ctrl read", rd, 0);
    check("R1", "ack after accept", cap_ack, 1);
    check("R1", "ack one cycle", post_ack, 0);

    // R2 power-up: CKE low, then high
    bus(1, 5'h00, 32'h0C);
    check("R2", "levels 0C", {dram_cke, dram_reset_n, dram_odt}, 3'b011);
    bus(1, 5'h00, 32'h0E);
    check("R2", "levels 0E", {dram_cke, dram_reset_n, dram_odt}, 3'b111);
    bus(0, 5'h00, 0); check("R2", "ctrl readback", rd, 32'h0E);

    // R3/R4 mode-register set to MR2
    bus(1, 5'h0C, 32'h200);
    bus(1, 5'h10, 32'h2);
    bus(0, 5'h0C, 0); check("R3", "addr readback", rd, 32'h200);
    bus(0, 5'h10, 0); check("R3", "bank readback", rd, 32'h2);
    bus(1, 5'h04, 32'h0F);
    check("R4", "MRS strobes", cap_pins, 4'h0);
    check("R3", "addr with strobe", cap_addr, 16'h200);
    check("R3", "bank with strobe", cap_bank, 3'd2);
    check("R5", "idle after cmd", post_pins, 4'hF);
    bus(0, 5'h04, 0); check("R4", "cmd reads zero", rd, 0);

    // Vector table walk
    foreach (VEC[i]) begin
      bus(1, 5'h0C, {16'h0, VEC[i][23:8]});
      bus(1, 5'h10, {24'h0, VEC[i][7:0]});
      check("R5", "idle before cmd", pins(), 4'hF);
      bus(1, 5'h04, {28'h0, VEC[i][31:28]});
      check("R4", "strobe map", cap_pins, VEC[i][27:24]);
      check("R3", "addr out", cap_addr, VEC[i][23:8]);
      check("R3", "bank out", cap_bank, VEC[i][2:0]);
      check("R4", "single cycle", post_pins, 4'hF);
    end

    // R8 unmapped offsets
    bus(1, 5'h0C, 32'h1111); bus(1, 5'h10, 32'h5);
    for (int a = 0; a < 4; a++) begin
      logic [4:0] off;
      off = (a == 0) ? 5'h08 : 5'(5'h14 + 4 * (a - 1));
      bus(1, off, 32'hFFFF_FFFF);
      check("R8", "no cmd on unmapped write", cap_pins, 4'hF);
      bus(0, off, 0); check("R8", "unmapped reads zero", rd, 0);
    end
    bus(0, 5'h00, 0); check("R8", "ctrl kept", rd, 32'h0E);
    bus(0, 5'h0C, 0); check("R8", "addr kept", rd, 32'h1111);
    bus(0, 5'h10, 0); check("R8", "bank kept", rd, 32'h5);

    // R9 reads issue nothing
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = 5'h04; wb_dat_i = 32'h0F;
    @(negedge clk); check("R9", "read cmd pins", pins(), 4'hF);
    wb_cyc = 0; wb_stb = 0;
    @(negedge clk); check("R9", "read cmd pins after", pins(), 4'hF);

    // R1 strobe without cycle
    wb_stb = 1; wb_we = 1; wb_adr = 5'h04; wb_dat_i = 32'h0F;
    @(negedge clk); check("R1", "no ack without cyc", wb_ack, 0);
    check("R1", "no cmd without cyc", pins(), 4'hF);
    wb_stb = 0; wb_we = 0;

    // R6 hardware hand-over
    hw_ras_n = 0; hw_cas_n = 1; hw_we_n = 0; hw_cs_n = 1;
    hw_addr = 16'hBEEF; hw_bank = 3'd6; hw_cke = 1; hw_reset_n = 0; hw_odt = 1;
    bus(1, 5'h00, 32'h01);
    check("R6", "pins follow hw", pins(), 4'b0101);
    check("R6", "addr follows hw", dram_addr, 16'hBEEF);
    check("R6", "bank follows hw", dram_bank, 3'd6);
    check("R6", "levels follow hw", {dram_cke, dram_reset_n, dram_odt}, 3'b101);
    hw_ras_n = 1; hw_we_n = 1; hw_addr = 16'h0042; #1;
    check("R6", "same-cycle hw", {pins(), dram_addr}, {4'hF, 16'h0042});
    bus(1, 5'h04, 32'h0F);
    check("R6", "sw cmd blocked", cap_pins, 4'hF);
    bus(1, 5'h00, 32'h0E);
    check("R6", "back to sw addr", dram_addr, 16'h1111);

    // R7 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R7", "levels after reset", {dram_cke, dram_reset_n, dram_odt}, 0);
    rst_n = 1;
    bus(0, 5'h0C, 0); check("R7", "addr cleared", rd, 0);
    bus(0, 5'h00, 0); check("R7", "ctrl cleared", rd, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule